// File: doc/BRIEF.md
# Vector Lane Rearrangement Unit

This block moves the elements of a short vector between lanes. A single operation code selects what it does. It can reorder lanes from a per-lane index, or shift the vector toward higher or lower lanes and fill the emptied lanes with a scalar. It can merge the low halves of two vectors alternately, or split one vector into its even and odd elements. It can also pack the lanes chosen by a mask into the bottom of the vector, or spread low source lanes out into the masked positions.

The block accepts one operation per cycle, with no back-pressure. Each result is captured in an output register, together with the number of set mask bits, and appears one clock after the request. Vector width and lane width are parameters; the default is 8 lanes of 16 bits. The lane count must be even.

Top module: `vperm_unit`

## Requirements
- R1: While reset is asserted and after it is released (before any request), `out_valid`, `result` and `count` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In a cycle without a request, `result` and `count` keep their previous values.
- R3: With `op`=0 (index reorder), lane i of `result` is lane `idx[i]` of `src_a`, where `idx[i]` is bits [i*IW +: IW] with IW=$clog2(N)+1. An index value of N or more gives zero in that lane.
- R4: With `op`=1 (shift toward higher lanes by `shamt`=k), lane i is `src_a` lane i-k when i>=k, and `fill` otherwise. When k>=N, every lane is `fill`.
- R5: With `op`=2 (shift toward lower lanes by k), lane i is `src_a` lane i+k when i+k<N, and `fill` otherwise.
- R6: With `op`=3 (interleave), lane 2j is `src_a` lane j and lane 2j+1 is `src_b` lane j, for j<N/2.
- R7: With `op`=4 (de-interleave), lane j is `src_a` lane 2j and lane N/2+j is `src_a` lane 2j+1, for j<N/2.
- R8: With `op`=5 (compress), the `src_a` lanes whose `mask` bit is set fill lanes 0,1,2,… in ascending source order. All lanes above them are zero.
- R9: With `op`=6 (expand), the lane holding the m-th set bit of `mask`, counting from 0, receives `src_a` lane m. Lanes with a clear mask bit are zero.
- R10: For every accepted request, `count` is the number of set bits in `mask`.
- R11: With `op`=7, `result` is all zero.
- All vectors place lane i at bits [i*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| src_a | input | N*W | Primary source vector |
| src_b | input | N*W | Second source vector, interleave only |
| idx | input | N*IW | Per-lane reorder indices |
| shamt | input | IW | Shift distance in lanes |
| fill | input | W | Scalar for lanes emptied by a shift |
| mask | input | N | Lane select for compress and expand |
| out_valid | output | 1 | Result strobe |
| result | output | N*W | Rearranged vector |
| count | output | $clog2(N+1) | Number of set mask bits |

## Verification
There are no hidden state machines: every fault in a lane route reaches `result` on the cycle after its request. A wrong running pointer in the pack logic shows in one of two ways. It can shift all later packed elements by one lane, or it can leave a non-zero value above the packed run; the `count` output often disagrees at the same edge. The bench sweeps all 256 masks for both mask operations and every shift distance from 0 to 15. An off-by-one at the lane boundary or an unfilled lane therefore shows within one request.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  typedef enum logic [2:0] {
    OP_SHUF   = 3'd0,
    OP_SLUP   = 3'd1,
    OP_SLDN   = 3'd2,
    OP_ZIP    = 3'd3,
    OP_UNZIP  = 3'd4,
    OP_PACK   = 3'd5,
    OP_UNPACK = 3'd6,
    OP_NONE   = 3'd7
  } vp_op_e;
endpackage

// File: rtl/vperm_route.sv
// Index reorder and both shift directions.
module vperm_route #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = $clog2(N) + 1
) (
  input  logic [N*W-1:0]  a,
  input  logic [N*IW-1:0] idx,
  input  logic [IW-1:0]   shamt,
  input  logic [W-1:0]    fill,
  output logic [N*W-1:0]  shuf,
  output logic [N*W-1:0]  slup,
  output logic [N*W-1:0]  sldn
);
  // Source lane for a shift toward higher lanes, -1 when vacated.
  function automatic int src_up(int lane, int k);
    return (k < N && lane >= k) ? lane - k : -1;
  endfunction

  // Source lane for a shift toward lower lanes, -1 when vacated.
  function automatic int src_dn(int lane, int k);
    return (k < N && lane + k < N) ? lane + k : -1;
  endfunction

  always_comb begin
    shuf = '0;
    for (int i = 0; i < N; i++) begin
      int sel;
      sel = int'(idx[i*IW +: IW]);
      if (sel < N) shuf[i*W +: W] = a[sel*W +: W];
    end
  end

  always_comb begin
    slup = '0;
    sldn = '0;
    for (int i = 0; i < N; i++) begin
      int su;
      int sd;
      su = src_up(i, int'(shamt));
      sd = src_dn(i, int'(shamt));
      slup[i*W +: W] = (su >= 0) ? a[su*W +: W] : fill;
      sldn[i*W +: W] = (sd >= 0) ? a[sd*W +: W] : fill;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (int'(idx[i*IW +: IW]) >= N)
        assert_shuf_oob_zero_R3: assert (shuf[i*W +: W] == '0);
    end
  end
endmodule

// File: rtl/vperm_zip.sv
// Interleave of two lower halves and even/odd split of one vector.
module vperm_zip #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N*W-1:0] a,
  input  logic [N*W-1:0] b,
  output logic [N*W-1:0] zip,
  output logic [N*W-1:0] unzip
);
  localparam int H = N / 2;

  logic unused_b_hi;
  assign unused_b_hi = ^b[N*W-1:H*W];

  for (genvar j = 0; j < H; j++) begin : g_pair
    assign zip[(2*j)*W +: W]   = a[j*W +: W];
    assign zip[(2*j+1)*W +: W] = b[j*W +: W];
    assign unzip[j*W +: W]     = a[(2*j)*W +: W];
    assign unzip[(H+j)*W +: W] = a[(2*j+1)*W +: W];
  end
endmodule

// File: rtl/vperm_pack.sv
// Mask-driven compress and expand, plus the set-bit count.
module vperm_pack #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N*W-1:0] a,
  input  logic [N-1:0]   mask,
  output logic [N*W-1:0] packed_v,
  output logic [N*W-1:0] spread_v,
  output logic [CW-1:0]  cnt
);
  // Compress: a write pointer advances on every selected lane.
  always_comb begin
    int p;
    packed_v = '0;
    p = 0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        packed_v[p*W +: W] = a[i*W +: W];
        p = p + 1;
      end
    end
    cnt = CW'(p);
  end

  // Expand: a read pointer advances on every selected lane.
  always_comb begin
    int q;
    spread_v = '0;
    q = 0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        spread_v[i*W +: W] = a[q*W +: W];
        q = q + 1;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (j >= int'(cnt))
        assert_pack_tail_zero_R8: assert (packed_v[j*W +: W] == '0);
      if (!mask[j])
        assert_spread_gap_zero_R9: assert (spread_v[j*W +: W] == '0);
    end
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = $clog2(N) + 1,
  parameter int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [N*W-1:0]  src_a,
  input  logic [N*W-1:0]  src_b,
  input  logic [N*IW-1:0] idx,
  input  logic [IW-1:0]   shamt,
  input  logic [W-1:0]    fill,
  input  logic [N-1:0]    mask,
  output logic            out_valid,
  output logic [N*W-1:0]  result,
  output logic [CW-1:0]   count
);
  import vperm_pkg::*;

  logic [N*W-1:0] shuf_v, slup_v, sldn_v, zip_v, unzip_v, pack_v, spread_v;
  logic [N*W-1:0] next_v;
  logic [CW-1:0]  pop_n;
  vp_op_e         op_e;

  assign op_e = vp_op_e'(op);

  vperm_route #(.N(N), .W(W), .IW(IW)) u_route (
    .a(src_a), .idx(idx), .shamt(shamt), .fill(fill),
    .shuf(shuf_v), .slup(slup_v), .sldn(sldn_v)
  );

  vperm_zip #(.N(N), .W(W)) u_zip (
    .a(src_a), .b(src_b), .zip(zip_v), .unzip(unzip_v)
  );

  vperm_pack #(.N(N), .W(W), .CW(CW)) u_pack (
    .a(src_a), .mask(mask), .packed_v(pack_v), .spread_v(spread_v), .cnt(pop_n)
  );

  always_comb begin
    unique case (op_e)
      OP_SHUF:   next_v = shuf_v;
      OP_SLUP:   next_v = slup_v;
      OP_SLDN:   next_v = sldn_v;
      OP_ZIP:    next_v = zip_v;
      OP_UNZIP:  next_v = unzip_v;
      OP_PACK:   next_v = pack_v;
      OP_UNPACK: next_v = spread_v;
      default:   next_v = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      count     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_v;
        count  <= pop_n;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(count)));
  assert_count_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (count == CW'($countones($past(mask)))));
endmodule

// File: tb/tb_vperm_unit.sv
module tb_vperm_unit;
  localparam int N     = 8;
  localparam int W     = 16;
  localparam int IW    = 4;
  localparam int CW    = 4;
  localparam int CLK_P = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [2:0]      op = '0;
  logic [N*W-1:0]  src_a = '0, src_b = '0;
  logic [N*IW-1:0] idx = '0;
  logic [IW-1:0]   shamt = '0;
  logic [W-1:0]    fill = '0;
  logic [N-1:0]    mask = '0;
  logic            out_valid;
  logic [N*W-1:0]  result;
  logic [CW-1:0]   count;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  vperm_unit #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .idx(idx), .shamt(shamt), .fill(fill),
    .mask(mask), .out_valid(out_valid), .result(result), .count(count)
  );

  task automatic check(string req, logic [N*W-1:0] got, logic [N*W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] lane(logic [N*W-1:0] v, int i);
    return v[i*W +: W];
  endfunction

  function automatic int ones(logic [N-1:0] m);
    int s = 0;
    for (int i = 0; i < N; i++) s += m[i];
    return s;
  endfunction

  function automatic logic [N*W-1:0] model(int o, logic [N*W-1:0] a, logic [N*W-1:0] b,
      logic [N*IW-1:0] ix, int k, logic [W-1:0] f, logic [N-1:0] m);
    logic [N*W-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] v = '0;
      case (o)
        0: begin
          int s = int'(ix[i*IW +: IW]);
          if (s < N) v = lane(a, s);
        end
        1: v = (i - k >= 0) ? lane(a, i - k) : f;
        2: v = (i + k < N) ? lane(a, i + k) : f;
        3: v = (i % 2 == 0) ? lane(a, i / 2) : lane(b, i / 2);
        4: v = (i < N/2) ? lane(a, 2*i) : lane(a, 2*(i - N/2) + 1);
        5: begin
          int c = 0;
          for (int s = 0; s < N; s++)
            if (m[s]) begin
              if (c == i) v = lane(a, s);
              c++;
            end
        end
        6: if (m[i]) v = lane(a, ones(m & ((N'(1) << i) - N'(1))));
        default: v = '0;
      endcase
      r[i*W +: W] = v;
    end
    return r;
  endfunction

  function automatic logic [N*W-1:0] rvec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic apply(string req, int o, int k, logic [N-1:0] m);
    logic [N*W-1:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    op = 3'(o);
    src_a = rvec();
    src_b = rvec();
    idx = {$urandom, $urandom};
    shamt = IW'(k);
    fill = W'($urandom);
    mask = m;
    exp = model(o, src_a, src_b, idx, k, fill, m);
    @(posedge clk);
    #1;
    check(req, result, exp);
    check({req, " count R10"}, N*W'(count), N*W'(ones(m)));
    check({req, " valid R2"}, N*W'(out_valid), N*W'(1));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog got=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N*W-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R1 result in reset", result, '0);
    check("R1 valid in reset", N*W'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 result after release", result, '0);
    check("R1 count after release", N*W'(count), '0);

    for (int t = 0; t < 40; t++) apply("R3 index reorder", 0, 0, N'($urandom));
    for (int k = 0; k < 16; k++) begin
      apply("R4 shift up", 1, k, N'($urandom));
      apply("R4 shift up", 1, k, N'($urandom));
      apply("R5 shift down", 2, k, N'($urandom));
      apply("R5 shift down", 2, k, N'($urandom));
    end
    for (int t = 0; t < 10; t++) apply("R6 interleave", 3, 0, N'($urandom));
    for (int t = 0; t < 10; t++) apply("R7 de-interleave", 4, 0, N'($urandom));
    for (int m = 0; m < 256; m++) apply("R8 compress", 5, 0, N'(m));
    for (int m = 0; m < 256; m++) apply("R9 expand", 6, 0, N'(m));
    for (int t = 0; t < 4; t++) apply("R11 unused op", 7, 0, N'($urandom));

    // R2: idle cycles leave outputs untouched and drop out_valid.
    apply("R2 setup", 5, 0, 8'hA5);
    held = result;
    @(negedge clk);
    in_valid = 1'b0;
    op = 3'd0;
    src_a = rvec();
    mask = 8'hFF;
    @(posedge clk);
    #1;
    check("R2 valid low when idle", N*W'(out_valid), '0);
    check("R2 result held when idle", result, held);
    check("R2 count held when idle", N*W'(count), N*W'(4));
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R2 valid returns", N*W'(out_valid), N*W'(1));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule